// File: doc/BRIEF.md
# Two-Operand Keypad Multiplier Controller

This block sits behind a keypad front end and turns two key entries into one product. The operator enters a first 4-bit number, which is taken from the key value bus while the key-valid strobe is high. The operator then presses confirm, enters a second number and presses confirm again. The controller then forms the 8-bit product from shifted, AND-masked partial products. It loads the product into an output register and goes straight back to waiting for a new first number.

The controller is a six-state machine clocked on one edge. Its states are `ST_INIT`, `ST_GET_A`, `ST_ACK_A`, `ST_GET_B`, `ST_ACK_B` and `ST_CALC`, and they are visited in that order. The named transitions are:
- init→get_a, unconditional.
- get_a→ack_a, taken on key-valid.
- ack_a→get_b, taken on confirm.
- get_b→ack_b, taken on key-valid.
- ack_b→calc, taken on confirm.
- calc→get_a, unconditional.

Every input is sampled on the clock edge. A confirm press therefore acts in the cycle it is seen, whatever the other inputs do. Keypad scanning, debouncing and display are handled elsewhere.

Top module: `opmul_ctrl`

## Requirements
- R1: An active-low asynchronous reset immediately forces the product output to 0, clears both operand registers and puts the machine in `ST_INIT`.
- R2: `ST_INIT` lasts exactly one cycle and ignores key-valid. The first key can be accepted on the second rising edge after reset is released.
- R3: In `ST_GET_A` or `ST_GET_B` with key-valid low, the machine keeps waiting and captures nothing.
- R4: In `ST_ACK_A` or `ST_ACK_B`, the machine stays until confirm is sampled high, and it advances on that same edge.
- R5: A key-valid pulse in a confirm-wait state does not change the operand already captured.
- R6: Confirm sampled in an operand-wait state is not remembered. A key entered together with confirm still needs a separate confirm to advance.
- R7: The product equals the exact unsigned product of the two captured 4-bit operands, as an 8-bit value, for all 256 operand pairs.
- R8: The product register changes only on the edge that leaves `ST_CALC` (or on reset). It holds its previous value throughout entry of the next pair.
- R9: After `ST_CALC` the machine returns to `ST_GET_A` without clearing the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_val | input | 4 | Key value from the keypad front end |
| key_valid | input | 1 | High while key_val carries a pressed key |
| confirm | input | 1 | Confirm button, sampled every cycle |
| product | output | 8 | Registered product of the two entered numbers |

## Verification
The multiply path is swept over every one of the 256 operand pairs. This separates a correct shift-and-add from one with a dropped or misaligned partial product or a truncated carry. Further entry sequences test the handshake:
- Key-valid is held high while the machine waits for confirm, which exposes any capture outside the operand-wait states.
- Key-valid and confirm arrive together, which exposes a machine that skips a step.
- Confirm arrives before any key, and long idle gaps are left, which tests the holding behaviour.
- A key is held high during the init cycle after reset.
- Reset is asserted between clock edges, both in the middle of an entry and after a product has been produced.

// File: rtl/opmul_pkg.sv
package opmul_pkg;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_GET_A = 3'd1,
        ST_ACK_A = 3'd2,
        ST_GET_B = 3'd3,
        ST_ACK_B = 3'd4,
        ST_CALC  = 3'd5
    } opmul_state_e;

endpackage

// File: rtl/opmul_fsm.sv
module opmul_fsm
    import opmul_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_valid,
    input  logic         confirm,
    output opmul_state_e state_o,
    output logic         clr_o,
    output logic         load_a_o,
    output logic         load_b_o,
    output logic         calc_o
);

    opmul_state_e state_q;
    opmul_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  state_d = ST_GET_A;
            ST_GET_A: if (key_valid) state_d = ST_ACK_A;
            ST_ACK_A: if (confirm)   state_d = ST_GET_B;
            ST_GET_B: if (key_valid) state_d = ST_ACK_B;
            ST_ACK_B: if (confirm)   state_d = ST_CALC;
            ST_CALC:  state_d = ST_GET_A;
            default:  state_d = ST_INIT;
        endcase
    end

    // per-state outputs
    always_comb begin
        clr_o    = 1'b0;
        load_a_o = 1'b0;
        load_b_o = 1'b0;
        calc_o   = 1'b0;
        unique case (state_q)
            ST_INIT:  clr_o    = 1'b1;
            ST_GET_A: load_a_o = key_valid;
            ST_GET_B: load_b_o = key_valid;
            ST_CALC:  calc_o   = 1'b1;
            default:  ;
        endcase
    end

    assign state_o = state_q;

    p_init_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_INIT |=> state_q == ST_GET_A);

    p_get_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GET_B && !key_valid) |=> state_q == ST_GET_B);

    p_ack_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_A && !confirm) |=> state_q == ST_ACK_A);

    p_ack_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_B && confirm) |=> state_q == ST_CALC);

    p_calc_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_CALC |=> state_q == ST_GET_A);

endmodule

// File: rtl/opmul_operand_reg.sv
module opmul_operand_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (clr)  q <= '0;
        else if (load) q <= d;
    end

    // R5: an operand only moves when its capture strobe fires
    p_operand_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(q));

endmodule

// File: rtl/opmul_shift_add.sv
module opmul_shift_add #(
    parameter int OPW = 4,
    localparam int PW = 2 * OPW
) (
    input  logic [OPW-1:0] a,
    input  logic [OPW-1:0] b,
    output logic [PW-1:0]  p
);

    logic [OPW-1:0][PW-1:0] part;

    for (genvar i = 0; i < OPW; i++) begin : g_part
        assign part[i] = PW'(a & {OPW{b[i]}}) << i;
    end

    always_comb begin
        p = '0;
        for (int i = 0; i < OPW; i++) p = p + part[i];
    end

endmodule

// File: rtl/opmul_ctrl.sv
module opmul_ctrl
    import opmul_pkg::*;
#(
    parameter int OPW = 4,
    localparam int PW = 2 * OPW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] key_val,
    input  logic           key_valid,
    input  logic           confirm,
    output logic [PW-1:0]  product
);

    opmul_state_e  state;
    logic          clr, load_a, load_b, calc;
    logic [OPW-1:0] op_a, op_b;
    logic [PW-1:0]  prod_next;

    opmul_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .confirm   (confirm),
        .state_o   (state),
        .clr_o     (clr),
        .load_a_o  (load_a),
        .load_b_o  (load_b),
        .calc_o    (calc)
    );

    opmul_operand_reg #(.W(OPW)) u_op_a (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .load (load_a), .d (key_val), .q (op_a)
    );

    opmul_operand_reg #(.W(OPW)) u_op_b (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .load (load_b), .d (key_val), .q (op_b)
    );

    opmul_shift_add #(.OPW(OPW)) u_mul (
        .a (op_a),
        .b (op_b),
        .p (prod_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    product <= '0;
        else if (clr)  product <= '0;
        else if (calc) product <= prod_next;
    end

    // R7: registered result matches a plain multiply of the captured operands
    p_product_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CALC |=> product == PW'(PW'($past(op_a)) * PW'($past(op_b))));

    // R8: outside the compute and init states the product is frozen
    p_product_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CALC && state != ST_INIT) |=> $stable(product));

endmodule

// File: tb/opmul_ctrl_tb.sv
`timescale 1ns/1ps
module opmul_ctrl_tb;

    localparam time TCLK = 4ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] key_val = '0;
    logic       key_valid = 1'b0;
    logic       confirm = 1'b0;
    logic [7:0] product;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] last = '0;

    always #(TCLK/2) clk = ~clk;

    opmul_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .key_val (key_val),
        .key_valid (key_valid), .confirm (confirm), .product (product)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: product got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drv(input logic [3:0] k, input logic v, input logic c);
        @(negedge clk);
        key_val = k; key_valid = v; confirm = c;
    endtask

    // final confirm in ack_b, then hold check in calc, then result check
    task automatic close_out(input logic [7:0] exp, input string tag);
        drv(4'd0, 1'b0, 1'b1);
        drv(4'd0, 1'b0, 1'b0);
        chk("R8 hold", product, last);
        drv(4'd0, 1'b0, 1'b0);
        chk(tag, product, exp);
        last = exp;
    endtask

    task automatic op(input logic [3:0] a, input logic [3:0] b, input string tag);
        drv(a, 1'b1, 1'b0);
        drv(4'd0, 1'b0, 1'b1);
        drv(b, 1'b1, 1'b0);
        close_out(8'(a * b), tag);
    endtask

    task automatic async_reset();
        @(negedge clk);
        key_valid = 1'b0; confirm = 1'b0;
        #1 rst_n = 1'b0;
        #0.5;
        chk("R1 async clear", product, 8'd0);
        last = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(TCLK * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", product, 8'd0);

        // R2: key held during the init cycle must not be taken
        key_val = 4'd7; key_valid = 1'b1;
        rst_n = 1'b1;
        drv(4'd0, 1'b0, 1'b0);
        op(4'd3, 4'd9, "R2 init ignores key");

        // R7: exhaustive sweep
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                op(4'(a), 4'(b), "R7 product");

        // R9: result kept while idling in get_a
        op(4'd15, 4'd15, "R7 max");
        repeat (4) drv(4'd0, 1'b0, 1'b0);
        chk("R9 no clear after calc", product, 8'd225);

        // R3: idle gaps in both operand waits
        repeat (3) drv(4'd0, 1'b0, 1'b0);
        drv(4'd10, 1'b1, 1'b0);
        drv(4'd0, 1'b0, 1'b1);
        repeat (3) drv(4'd0, 1'b0, 1'b0);
        drv(4'd7, 1'b1, 1'b0);
        close_out(8'd70, "R3 wait without key");

        // R4: long confirm waits
        drv(4'd12, 1'b1, 1'b0);
        repeat (4) drv(4'd0, 1'b0, 1'b0);
        drv(4'd0, 1'b0, 1'b1);
        drv(4'd5, 1'b1, 1'b0);
        repeat (4) drv(4'd0, 1'b0, 1'b0);
        chk("R4 no advance without confirm", product, last);
        close_out(8'd60, "R4 confirm wait");

        // R5: keys during confirm waits ignored
        drv(4'd6, 1'b1, 1'b0);
        drv(4'd15, 1'b1, 1'b0);
        drv(4'd0, 1'b0, 1'b1);
        drv(4'd2, 1'b1, 1'b0);
        drv(4'd11, 1'b1, 1'b0);
        close_out(8'd12, "R5 key in confirm wait");

        // R6: confirm in operand wait not remembered
        drv(4'd0, 1'b0, 1'b1);
        drv(4'd0, 1'b0, 1'b1);
        drv(4'd5, 1'b1, 1'b1);
        drv(4'd9, 1'b1, 1'b0);
        drv(4'd0, 1'b0, 1'b1);
        drv(4'd3, 1'b1, 1'b0);
        close_out(8'd15, "R6 confirm not latched");

        // R1: reset after a product, and mid-entry
        async_reset();
        op(4'd13, 4'd11, "R1 after reset");
        drv(4'd4, 1'b1, 1'b0);
        drv(4'd0, 1'b0, 1'b1);
        async_reset();
        op(4'd8, 4'd14, "R1 mid-entry reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule